// File: doc/BRIEF.md
# FP32 Normalise-and-Round Unit

This unit is the shared back end of a single-precision arithmetic datapath. An operation hands it an unpacked intermediate: a sign, a signed biased exponent and a 32-bit significand that keeps extra low-order bits beyond the final result's precision. One clock later the unit returns a packed IEEE-754 binary32 word together with a 4-bit exception vector. The operations upstream only need to produce a rough significand and an exponent that match each other. Leading-zero normalisation, gradual underflow, the rounding decision, carry handling and overflow saturation all happen here.

The value of a non-special input is `in_sig * 2^(in_exp - 157)`. For a significand whose leading one sits at bit 30, `in_exp` is therefore the ordinary biased exponent. Inputs at exponent 255 are treated as special in two cases: when the significand is zero, or when the caller has already flagged an exception. These inputs bypass all arithmetic, so the caller can present an infinity or a NaN it has already chosen.

Top module: `fp32_norm_round`

## Requirements
- R1: Timing of the output.
  - `out_valid` is low during and after reset until the first input.
  - Each cycle that has `in_valid` high produces exactly one result, with `out_valid` high on the next clock edge.
  - An idle cycle yields `out_valid` low.
- R2: Special inputs pass straight through.
  - This applies when `in_exp` is 255 and either `in_sig` is zero or `in_exc` is non-zero.
  - The word is sign, exponent field 0xFF, and mantissa `in_sig[29:7]`.
  - `out_flags` equals `in_exc`.
  - The flag vector is bit 3 overflow, bit 2 underflow, bit 1 inexact, bit 0 invalid.
- R3: A zero `in_sig` (outside R2) packs to a zero carrying `in_sign`. `out_flags` equals `in_exc`, and no new flag is added.
- R4: Normalisation.
  - A non-zero significand is first shifted left until its top bit is set, with the exponent reduced to match.
  - Equal values therefore pack identically whatever their input alignment.
  - The output sign always equals `in_sign`.
- R5: Mode 0 (nearest) rounds to the nearest representable value. Exact ties go to the even mantissa.
- R6: Mode 3 truncates toward zero. Mode 1 rounds positive values up, and mode 2 rounds negative values up in magnitude. Otherwise these two directed modes truncate.
- R7: When rounding carries out of the mantissa, the result becomes the next power of two and the exponent rises by one.
- R8: Inexact (bit 1) is set whenever any bit discarded by rounding or by a denormalising shift is non-zero. An exactly representable result raises no flag.
- R9: Overflow behaviour.
  - A result whose biased exponent would reach 255 sets overflow and inexact.
  - The word is infinity when the mode may round this sign's magnitude up. That covers mode 0, mode 1 with a positive sign, and mode 2 with a negative sign.
  - In every other case the word is the largest finite magnitude, 0x7F7FFFFF with the sign applied.
- R10: Tiny results.
  - A result below the normal range is shifted right into denormal position.
  - Every bit shifted out is ORed into the lowest kept bit, so it still influences rounding.
  - Underflow (bit 2) is set only when such a result is both inexact and still below the normal range after rounding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input qualifier |
| in_sign | input | 1 | Sign of the intermediate |
| in_exp | input | EXP_W | Signed biased exponent |
| in_sig | input | SIG_W | Unnormalised significand |
| in_rmode | input | 2 | Rounding mode: 0 nearest, 1 toward +inf, 2 toward -inf, 3 toward zero |
| in_exc | input | 4 | Exceptions already raised upstream, same encoding as out_flags |
| out_valid | output | 1 | Result qualifier |
| out_word | output | 32 | Packed binary32 result |
| out_flags | output | 4 | {overflow, underflow, inexact, invalid} |

## Verification
The hardest situation to reach from the ports is a tiny result in which the only non-zero discarded information is the sticky bit produced by the denormalising shift. Directed rounding must still see that bit and bump the result, and underflow must fire only if the rounded value stays denormal. The stimulus reaches this case with very negative exponents and significands whose lowest set bit falls out during the shift, including shifts far longer than the word. It pairs these with a largest-denormal input that rounds up into the normal range. Carry-induced overflow at the top of the range is reached the same way, with an all-ones mantissa at the last finite exponent.

// File: rtl/fp32nr_pkg.sv
package fp32nr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_UP   = 2'd1,
    RM_DOWN = 2'd2,
    RM_ZERO = 2'd3
  } rmode_e;

  localparam int MANT_W   = 23;
  localparam int FIELD_W  = 8;
  localparam int FLAG_W   = 4;
  localparam int FL_OVF   = 3;
  localparam int FL_UNF   = 2;
  localparam int FL_INX   = 1;
  localparam int FL_INV   = 0;
endpackage

// File: rtl/fp32nr_lzc.sv
module fp32nr_lzc #(
  parameter int W  = 32,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (d[i]) cnt = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fp32nr_shr_jam.sv
module fp32nr_shr_jam #(
  parameter int W   = 32,
  localparam int AW = $clog2(W) + 1
) (
  input  logic [W-1:0]  d,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  q
);
  logic [W-1:0] kept;
  logic [W-1:0] drop_mask;
  logic         lost;

  always_comb begin
    kept      = d >> amt;
    drop_mask = ~({W{1'b1}} << amt);
    lost      = |(d & drop_mask);
    q         = kept | {{(W-1){1'b0}}, lost};
  end
endmodule

// File: rtl/fp32nr_round.sv
module fp32nr_round
  import fp32nr_pkg::*;
#(
  parameter int W   = 32,
  localparam int G  = W - MANT_W - 1,
  localparam int MW = W - G
) (
  input  logic          sign,
  input  rmode_e        rmode,
  input  logic [W-1:0]  sig,
  output logic [MW-1:0] mant,
  output logic          carry,
  output logic          top_set,
  output logic          inexact,
  output logic          up_allowed
);
  logic          half, below, lsb, bump;
  logic [MW:0]   sum;

  always_comb begin
    half    = sig[G-1];
    below   = |sig[G-2:0];
    lsb     = sig[G];
    inexact = half | below;
    up_allowed = (rmode == RM_NEAR) ||
                 (rmode == RM_UP   && !sign) ||
                 (rmode == RM_DOWN &&  sign);
    unique case (rmode)
      RM_NEAR: bump = half & (below | lsb);
      RM_ZERO: bump = 1'b0;
      default: bump = inexact & up_allowed;
    endcase
    sum     = {1'b0, sig[W-1:G]} + (MW+1)'(bump);
    carry   = sum[MW];
    mant    = carry ? sum[MW:1] : sum[MW-1:0];
    top_set = carry | sum[MW-1];
  end
endmodule

// File: rtl/fp32_norm_round.sv
module fp32_norm_round
  import fp32nr_pkg::*;
#(
  parameter int EXP_W = 10,
  parameter int SIG_W = 32,
  localparam int IW   = EXP_W + 2,
  localparam int LZW  = $clog2(SIG_W),
  localparam int SAW  = $clog2(SIG_W) + 1,
  localparam int G    = SIG_W - MANT_W - 1,
  localparam int MW   = SIG_W - G
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0]        in_sig,
  input  logic [1:0]              in_rmode,
  input  logic [FLAG_W-1:0]       in_exc,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic [FLAG_W-1:0]       out_flags
);
  localparam logic signed [IW-1:0] SPECIAL_E = IW'(255);
  localparam logic signed [IW-1:0] OVF_E     = IW'(254);
  localparam logic signed [IW-1:0] SIG_W_S   = IW'(SIG_W);

  logic signed [IW-1:0] e_ext, e_norm, neg_e, e_pre, e_post;
  logic [LZW-1:0]       lz;
  logic [SIG_W-1:0]     nsig, dsig;
  logic [SAW-1:0]       amt;
  logic                 is_special, is_zero, tiny, ovf, unf;
  logic [MW-1:0]        mant;
  logic                 carry, top_set, inexact, up_ok;
  logic [FIELD_W-1:0]   field;
  logic [31:0]          word_d;
  logic [FLAG_W-1:0]    flags_d;

  fp32nr_lzc #(.W(SIG_W)) u_lzc (.d(in_sig), .cnt(lz));

  always_comb begin
    e_ext      = IW'(in_exp);
    is_zero    = (in_sig == '0);
    is_special = (e_ext == SPECIAL_E) && (is_zero || (in_exc != '0));
    nsig       = in_sig << lz;
    e_norm     = e_ext - $signed({{(IW-LZW){1'b0}}, lz});
    tiny       = e_norm[IW-1];
    neg_e      = -e_norm;
    if (!tiny)                amt = '0;
    else if (neg_e > SIG_W_S) amt = SAW'(SIG_W);
    else                      amt = neg_e[SAW-1:0];
    e_pre      = tiny ? '0 : e_norm;
  end

  fp32nr_shr_jam #(.W(SIG_W)) u_shr (.d(nsig), .amt(amt), .q(dsig));

  fp32nr_round #(.W(SIG_W)) u_rnd (
    .sign(in_sign), .rmode(rmode_e'(in_rmode)), .sig(dsig),
    .mant(mant), .carry(carry), .top_set(top_set),
    .inexact(inexact), .up_allowed(up_ok)
  );

  always_comb begin
    e_post = e_pre + $signed({{(IW-1){1'b0}}, carry});
    ovf    = (e_post >= OVF_E);
    unf    = tiny && inexact && !top_set;
    field  = e_post[FIELD_W-1:0] + {{(FIELD_W-1){1'b0}}, mant[MW-1]};
    if (is_special) begin
      word_d  = {in_sign, 8'hFF, in_sig[SIG_W-3 -: MANT_W]};
      flags_d = in_exc;
    end else if (is_zero) begin
      word_d  = {in_sign, 31'd0};
      flags_d = in_exc;
    end else if (ovf) begin
      word_d  = up_ok ? {in_sign, 8'hFF, 23'd0} : {in_sign, 8'hFE, 23'h7FFFFF};
      flags_d = in_exc | 4'b1010;
    end else begin
      word_d  = {in_sign, field, mant[MANT_W-1:0]};
      flags_d = in_exc | {1'b0, unf, inexact, 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= word_d;
        out_flags <= flags_d;
      end
    end
  end
endmodule

// File: rtl/fp32_norm_round_chk.sv
module fp32_norm_round_chk #(
  parameter int EXP_W = 10,
  parameter int SIG_W = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_sign,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [SIG_W-1:0]        in_sig,
  input logic [1:0]              in_rmode,
  input logic                    out_valid,
  input logic [31:0]             out_word,
  input logic [2:0]              of_uf_ix
);
  logic exp_is_255;
  assign exp_is_255 = (in_exp == EXP_W'(255));

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_inf_pass_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid && exp_is_255 && in_sig == '0 |=> out_word[30:0] == 31'h7F800000);
  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid && !exp_is_255 && in_sig == '0 |=> out_word[30:0] == 31'd0);
  assert_sign_kept_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_word[31] == $past(in_sign));
  assert_trunc_finite_R6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_rmode == 2'd3 && !exp_is_255 |=> out_word[30:23] != 8'hFF);
  assert_ovf_inexact_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && of_uf_ix[2] |-> of_uf_ix[0]);
  assert_unf_inexact_R10: assert property (@(posedge clk) disable iff (rst)
    out_valid && of_uf_ix[1] |-> of_uf_ix[0] && !of_uf_ix[2]);
endmodule

bind fp32_norm_round fp32_norm_round_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
  .in_exp(in_exp), .in_sig(in_sig), .in_rmode(in_rmode),
  .out_valid(out_valid), .out_word(out_word), .of_uf_ix(out_flags[3:1])
);

// File: tb/fp32_norm_round_tb.sv
`timescale 1ns/1ps
module fp32_norm_round_tb;
  localparam int EXP_W = 10;
  localparam int SIG_W = 32;

  logic                    clk = 1'b0;
  logic                    rst = 1'b1;
  logic                    in_valid = 1'b0;
  logic                    in_sign = 1'b0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [SIG_W-1:0]        in_sig = '0;
  logic [1:0]              in_rmode = 2'd0;
  logic [3:0]              in_exc = 4'd0;
  logic                    out_valid;
  logic [31:0]             out_word;
  logic [3:0]              out_flags;

  int checks = 0;
  int errors = 0;
  bit reported = 1'b0;

  logic [35:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  fp32_norm_round #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_rmode(in_rmode), .in_exc(in_exc),
    .out_valid(out_valid), .out_word(out_word), .out_flags(out_flags)
  );

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic send(input logic s, input int e, input logic [31:0] sg,
                      input logic [1:0] rm, input logic [3:0] x,
                      input logic [31:0] ew, input logic [3:0] ef, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_exp = EXP_W'(e);
    in_sig = sg; in_rmode = rm; in_exc = x;
    exp_q.push_back({ew, ef});
    tag_q.push_back(tag);
  endtask

  // monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected result word %h flags %b, expected none", out_word, out_flags);
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (out_word !== e[35:4] || out_flags !== e[3:0]) begin
          errors++;
          $display("FAIL %s: word %h flags %b, expected word %h flags %b",
                   t, out_word, out_flags, e[35:4], e[3:0]);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'd0) begin
      errors++;
      $display("FAIL R1: reset out_valid %b word %h, expected 0 and 0", out_valid, out_word);
    end
    rst = 1'b0;

    // R4: normalisation from several alignments
    send(0, 127, 32'h4000_0000, 2'd0, 4'h0, 32'h3F80_0000, 4'b0000, "R4 one");
    send(0, 149, 32'h0000_0100, 2'd0, 4'h0, 32'h3F80_0000, 4'b0000, "R4 low aligned");
    send(0, 126, 32'h8000_0000, 2'd0, 4'h0, 32'h3F80_0000, 4'b0000, "R4 top aligned");
    send(0, 254, 32'h4000_0000, 2'd0, 4'h0, 32'h7F00_0000, 4'b0000, "R8 exact largest exponent");
    // R3: zero
    send(1, 100, 32'h0,         2'd0, 4'h0, 32'h8000_0000, 4'b0000, "R3 negative zero");
    send(0, 5,   32'h0,         2'd1, 4'h1, 32'h0000_0000, 4'b0001, "R3 zero keeps upstream flag");
    // R2: specials
    send(0, 255, 32'h0,         2'd0, 4'h0, 32'h7F80_0000, 4'b0000, "R2 infinity");
    send(0, 255, 32'h6000_0000, 2'd0, 4'h1, 32'h7FC0_0000, 4'b0001, "R2 nan with flag");
    send(0, 255, 32'h4000_0000, 2'd0, 4'h0, 32'h7F80_0000, 4'b1010, "R2 not special without flag");
    // R5: nearest even
    send(0, 127, 32'h4000_0040, 2'd0, 4'h0, 32'h3F80_0000, 4'b0010, "R5 tie to even down");
    send(0, 127, 32'h4000_00C0, 2'd0, 4'h0, 32'h3F80_0002, 4'b0010, "R5 tie to even up");
    send(0, 127, 32'h4000_0041, 2'd0, 4'h0, 32'h3F80_0001, 4'b0010, "R5 above half");
    send(0, 127, 32'h4000_003F, 2'd0, 4'h0, 32'h3F80_0000, 4'b0010, "R5 below half");
    // R6: directed and truncation
    send(0, 127, 32'h4000_007F, 2'd3, 4'h0, 32'h3F80_0000, 4'b0010, "R6 toward zero");
    send(0, 127, 32'h4000_0001, 2'd1, 4'h0, 32'h3F80_0001, 4'b0010, "R6 up positive");
    send(1, 127, 32'h4000_0001, 2'd1, 4'h0, 32'hBF80_0000, 4'b0010, "R6 up negative");
    send(1, 127, 32'h4000_0001, 2'd2, 4'h0, 32'hBF80_0001, 4'b0010, "R6 down negative");
    send(0, 127, 32'h4000_0001, 2'd2, 4'h0, 32'h3F80_0000, 4'b0010, "R6 down positive");
    // R7: carry out
    send(0, 127, 32'h7FFF_FFC0, 2'd0, 4'h0, 32'h4000_0000, 4'b0010, "R7 carry to power of two");
    // R9: overflow
    send(0, 300, 32'h4000_0000, 2'd0, 4'h0, 32'h7F80_0000, 4'b1010, "R9 nearest to infinity");
    send(0, 300, 32'h4000_0000, 2'd3, 4'h0, 32'h7F7F_FFFF, 4'b1010, "R9 zero mode max finite");
    send(0, 300, 32'h4000_0000, 2'd2, 4'h0, 32'h7F7F_FFFF, 4'b1010, "R9 down positive max finite");
    send(1, 300, 32'h4000_0000, 2'd2, 4'h0, 32'hFF80_0000, 4'b1010, "R9 down negative infinity");
    send(0, 254, 32'h7FFF_FFC0, 2'd0, 4'h0, 32'h7F80_0000, 4'b1010, "R7 R9 carry into overflow");
    // R10: tiny
    send(0, -22, 32'h4000_0000, 2'd0, 4'h0, 32'h0000_0001, 4'b0000, "R10 exact smallest denormal");
    send(0, -23, 32'h4000_0000, 2'd0, 4'h0, 32'h0000_0000, 4'b0110, "R10 tie to zero");
    send(0, -23, 32'h4000_0000, 2'd1, 4'h0, 32'h0000_0001, 4'b0110, "R10 up to smallest");
    send(0, -21, 32'h4000_0001, 2'd0, 4'h0, 32'h0000_0002, 4'b0110, "R10 sticky nearest");
    send(0, -21, 32'h4000_0001, 2'd1, 4'h0, 32'h0000_0003, 4'b0110, "R10 sticky drives up");
    send(0, -400, 32'h4000_0000, 2'd1, 4'h0, 32'h0000_0001, 4'b0110, "R10 long shift up");
    send(0, -400, 32'h4000_0000, 2'd0, 4'h0, 32'h0000_0000, 4'b0110, "R10 long shift nearest");
    send(0, 0,   32'h7FFF_FFC0, 2'd0, 4'h0, 32'h0080_0000, 4'b0010, "R10 rounds into normal no underflow");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: idle out_valid %b pending %0d, expected 0 and 0", out_valid, exp_q.size());
    end
    report();
  end
endmodule